// File: doc/BRIEF.md
# Click-Free Gain Change Scheduler

This block sits between a gain setting and the stage that applies it on one audio channel. A new gain value is not applied when it is written. It is held as pending until the channel's sample stream next crosses zero, because a gain step at that point makes no audible click. A signal that stays on one side of zero for a long time, such as silence with a DC offset, would leave the write stuck. For that case the block has an optional fallback: a slow timeout clock forces the pending value out.

The timeout is counted in ticks of a 4 kHz reference. That reference is divided from the system clock by the parameter `TICK_DIV`, which is set to the system clock frequency divided by 4000. A 2-bit select chooses how many reference ticks make one timeout period. Each time a gain value is applied, the block raises a pulse that lasts one cycle. Downstream logic can use that pulse to latch the new gain into the analog stage.

Top module: `zc_gain_update`

## Requirements
- R1: After a synchronous active-low reset, `gain_out` equals the parameter `RESET_GAIN` (default 0), `gain_upd` is low and no write is pending.
- R2: Samples are two's complement, and bit SAMPLE_W-1 is the sign. When a write is pending and a valid sample has the opposite sign to the previous valid sample, the pending value appears on `gain_out` at that clock edge. `gain_upd` is high for the cycle that follows the edge.
- R3: A valid sample exactly equal to zero counts as a crossing on its own. A zero sample counts as non-negative when it is compared with the next sample.
- R4: A crossing that arrives while no write is pending produces no pulse and leaves `gain_out` unchanged.
- R5: With `to_en` high, a pending write is forced out on the L-th 4 kHz tick after the write. L is 32, 16, 8 and 4 for `to_sel` 00, 01, 10 and 11, which is 8, 4, 2 and 1 ms. The update therefore lands between (L-1)*TICK_DIV+1 and L*TICK_DIV cycles after the write edge.
- R6: While `to_en` is low, no forced update happens, however long the write waits.
- R7: A write made while another is pending replaces the pending value and restarts the timeout count. Only the latest value is applied, and only one pulse is raised.
- R8: Each update gives exactly one `gain_upd` cycle, and two pulses are never adjacent. `gain_out` does not change in any other cycle.
- R9: A write wins over a crossing or an expiry in the same cycle. The new value stays pending and nothing is applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| to_en | input | 1 | Enables the forced update on timeout |
| to_sel | input | 2 | Chooses the timeout period (00 is the longest) |
| smp_data | input | SAMPLE_W | Signed audio sample |
| smp_valid | input | 1 | Marks `smp_data` as a new sample |
| gain_wdata | input | GAIN_W | Requested gain value |
| gain_wr | input | 1 | Write strobe for `gain_wdata` |
| gain_out | output | GAIN_W | Gain value currently applied |
| gain_upd | output | 1 | One-cycle pulse raised when `gain_out` takes a new value |

## Verification
The hardest case to reach from the ports is the timeout boundary. The 4 kHz reference runs freely, so its phase relative to a write is unknown. This makes the exact update cycle uncertain within one tick period. The bench counts cycles from each write edge and accepts only updates inside the window that R5 gives. It does this for every select value, and it keeps samples idle so that no crossing can interfere. Restart on overwrite is shown by a second write made partway through a period. The resulting update must land a full period after the second write, which would not happen if the count had carried on from the first.

// File: rtl/zcu_pkg.sv
// Shared constants and helpers for the zero-cross gain scheduler.
package zcu_pkg;
    // Widest timeout, in 4 kHz ticks (select 00).
    localparam int unsigned MAX_TICKS = 32;
    localparam int unsigned TCNT_W    = $clog2(MAX_TICKS) + 1;

    // Number of reference ticks in one timeout period for a select value.
    function automatic logic [TCNT_W-1:0] ticks_for_sel(input logic [1:0] sel);
        logic [TCNT_W-1:0] base;
        base = TCNT_W'(MAX_TICKS);
        return base >> sel;
    endfunction
endpackage

// File: rtl/zcu_tick_gen.sv
// Free-running divider that makes a one-cycle 4 kHz reference tick.
// Assumes TICK_DIV >= 2 and TICK_DIV = system clock frequency / 4000.
module zcu_tick_gen #(
    parameter int unsigned TICK_DIV = 3072
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DW = $clog2(TICK_DIV);
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST);

    // Count system clocks and wrap once per reference period.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/zcu_zc_detect.sv
// Flags a zero crossing: a valid sample of the other sign from the last
// valid sample, or a valid sample equal to zero. Zero counts as non-negative.
// Assumes samples are two's complement.
module zcu_zc_detect #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic                zc
);
    logic prev_neg_q;
    logic prev_seen_q;
    logic cur_neg;
    logic is_zero;

    assign cur_neg = smp_data[SAMPLE_W-1];
    assign is_zero = (smp_data == '0);
    assign zc      = smp_valid && (is_zero || (prev_seen_q && (cur_neg != prev_neg_q)));

    // Remember the sign of the last valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg_q  <= 1'b0;
            prev_seen_q <= 1'b0;
        end else if (smp_valid) begin
            prev_neg_q  <= cur_neg;
            prev_seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/zcu_to_timer.sv
// Counts reference ticks since the last gain write and flags expiry.
// The count saturates one short of the widest period. Expiry needs the
// enable, so a disabled timeout never forces an update.
module zcu_to_timer
    import zcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic       to_en,
    input  logic [1:0] to_sel,
    output logic       expire
);
    logic [TCNT_W-1:0] cnt_q;
    logic [TCNT_W-1:0] limit_m1;
    logic              at_limit;

    assign limit_m1 = ticks_for_sel(to_sel) - 1'b1;
    assign at_limit = (cnt_q >= limit_m1);
    assign expire   = run && to_en && tick && at_limit && !restart;

    // Clear on a write, then count ticks while a value is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (run && tick && cnt_q != TCNT_W'(MAX_TICKS - 1))
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/zc_gain_update.sv
// Holds a written gain value pending and applies it at the next zero
// crossing of the sample stream, or at timeout expiry when that is enabled.
// A write in the same cycle as a trigger takes precedence.
module zc_gain_update #(
    parameter int unsigned GAIN_W     = 8,
    parameter int unsigned SAMPLE_W   = 16,
    parameter int unsigned TICK_DIV   = 3072,
    parameter logic [GAIN_W-1:0] RESET_GAIN = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                to_en,
    input  logic [1:0]          to_sel,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    input  logic [GAIN_W-1:0]   gain_wdata,
    input  logic                gain_wr,
    output logic [GAIN_W-1:0]   gain_out,
    output logic                gain_upd
);
    logic              tick;
    logic              zc;
    logic              expire;
    logic              pend_v_q;
    logic [GAIN_W-1:0] pend_gain_q;
    logic              apply;

    zcu_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    zcu_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data),
        .smp_valid(smp_valid), .zc(zc)
    );

    zcu_to_timer u_to (
        .clk(clk), .rst_n(rst_n), .restart(gain_wr), .run(pend_v_q),
        .tick(tick), .to_en(to_en), .to_sel(to_sel), .expire(expire)
    );

    assign apply = pend_v_q && !gain_wr && (zc || expire);

    // Capture writes as pending; clear the pending flag when applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q    <= 1'b0;
            pend_gain_q <= '0;
        end else if (gain_wr) begin
            pend_v_q    <= 1'b1;
            pend_gain_q <= gain_wdata;
        end else if (apply) begin
            pend_v_q    <= 1'b0;
        end
    end

    // Move the pending value to the output and pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_out <= RESET_GAIN;
            gain_upd <= 1'b0;
        end else begin
            gain_upd <= apply;
            if (apply) gain_out <= pend_gain_q;
        end
    end
endmodule

// File: rtl/zc_gain_update_chk.sv
// Checker for zc_gain_update, attached by bind. It watches the ports and
// the crossing and pending signals that separate submodules drive.
module zc_gain_update_chk #(
    parameter int unsigned GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gain_wr,
    input logic              to_en,
    input logic              zc,
    input logic [GAIN_W-1:0] pend_gain_q,
    input logic [GAIN_W-1:0] gain_out,
    input logic              gain_upd
);
    // R8: an update pulse never lasts into a second cycle.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |=> !gain_upd);

    // R8: the output holds unless a pulse marks a change.
    p_gain_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_upd |-> $stable(gain_out));

    // R6: every update comes from a crossing or from an enabled timeout.
    p_no_forced_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |-> ($past(zc) || $past(to_en)));

    // R9: a write blocks any update on the same edge.
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gain_wr |=> !gain_upd);

    // R2: the applied value is the value that was pending.
    p_value_from_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |-> (gain_out == $past(pend_gain_q)));
endmodule

bind zc_gain_update zc_gain_update_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .to_en(to_en), .zc(zc),
    .pend_gain_q(pend_gain_q), .gain_out(gain_out), .gain_upd(gain_upd)
);

// File: tb/zc_gain_update_tb.sv
`timescale 1ns/1ps
module zc_gain_update_tb;
    localparam int GW = 8;
    localparam int SW = 16;
    localparam int TD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          to_en = 1'b0;
    logic [1:0]    to_sel = 2'b00;
    logic [SW-1:0] smp_data = '0;
    logic          smp_valid = 1'b0;
    logic [GW-1:0] gain_wdata = '0;
    logic          gain_wr = 1'b0;
    logic [GW-1:0] gain_out;
    logic          gain_upd;

    int n_chk = 0;
    int n_bad = 0;
    logic [GW-1:0] exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    zc_gain_update #(.GAIN_W(GW), .SAMPLE_W(SW), .TICK_DIV(TD)) u_dut (
        .clk(clk), .rst_n(rst_n), .to_en(to_en), .to_sel(to_sel),
        .smp_data(smp_data), .smp_valid(smp_valid), .gain_wdata(gain_wdata),
        .gain_wr(gain_wr), .gain_out(gain_out), .gain_upd(gain_upd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each update pulse pops an expected value and compares it.
    always @(negedge clk) begin
        if (rst_n && gain_upd && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected update", int'(gain_out), -1);
            end else begin
                logic [GW-1:0] e;
                e = exp_q.pop_front();
                check(gain_out == e, "R2/R5/R7 applied value", int'(gain_out), int'(e));
            end
        end
    end

    task automatic write_gain(input logic [GW-1:0] g);
        @(negedge clk);
        gain_wr = 1'b1; gain_wdata = g;
        @(negedge clk);
        gain_wr = 1'b0;
    endtask

    task automatic send(input int v);
        @(negedge clk);
        smp_data = SW'(v); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Count cycles from the write edge until the update pulse.
    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!gain_upd && n < 400);
    endtask

    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(gain_out == 8'h00, "R1 gain_out", int'(gain_out), 0);
        check(gain_upd == 1'b0, "R1 gain_upd", int'(gain_upd), 0);

        // R4: crossings with nothing pending do nothing
        send(100);
        send(-100);
        check(gain_out == 8'h00 && !gain_upd, "R4 no pending", int'(gain_out), 0);

        // R2: sign change applies the pending value
        write_gain(8'h55);
        send(-20);
        check(gain_out == 8'h00 && !gain_upd, "R2 same sign holds", int'(gain_out), 0);
        exp_q.push_back(8'h55);
        send(30);
        check(gain_upd == 1'b1, "R2 pulse on crossing", int'(gain_upd), 1);
        @(negedge clk);
        check(gain_upd == 1'b0, "R8 pulse one cycle", int'(gain_upd), 0);

        // R3: an exact zero sample triggers
        write_gain(8'h22);
        send(40);
        check(gain_out == 8'h55, "R3 no crossing yet", int'(gain_out), 8'h55);
        exp_q.push_back(8'h22);
        send(0);
        check(gain_upd == 1'b1 && gain_out == 8'h22, "R3 zero sample", int'(gain_out), 8'h22);

        // R9: a write together with a crossing stays pending
        @(negedge clk);
        gain_wr = 1'b1; gain_wdata = 8'h44; smp_data = SW'(-5); smp_valid = 1'b1;
        @(negedge clk);
        gain_wr = 1'b0; smp_valid = 1'b0;
        check(!gain_upd && gain_out == 8'h22, "R9 write wins", int'(gain_out), 8'h22);
        exp_q.push_back(8'h44);
        send(7);
        check(gain_upd == 1'b1, "R9 applied later", int'(gain_upd), 1);

        // R6: no forced update with the timeout disabled
        to_en = 1'b0; to_sel = 2'b11;
        write_gain(8'h33);
        n = 0;
        repeat (400) begin
            @(negedge clk);
            if (gain_upd) n++;
        end
        check(n == 0 && gain_out == 8'h44, "R6 disabled timeout", n, 0);
        exp_q.push_back(8'h33);
        send(-9);
        check(gain_upd == 1'b1, "R6 crossing still applies", int'(gain_upd), 1);

        // R5: forced update for each select value
        to_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            int lim;
            lim = 32 >> s;
            to_sel = 2'(s);
            @(negedge clk);
            exp_q.push_back(GW'(8'h10 + s));
            write_gain(GW'(8'h10 + s));
            wait_upd(n);
            check(n >= (lim - 1) * TD + 1 && n <= lim * TD, "R5 timeout window", n, lim * TD);
        end

        // R7: an overwrite restarts the count and only the latest applies
        to_sel = 2'b11;
        write_gain(8'h61);
        n = 0;
        repeat (24) begin
            @(negedge clk);
            if (gain_upd) n++;
        end
        check(n == 0, "R7 no early update", n, 0);
        exp_q.push_back(8'h62);
        write_gain(8'h62);
        wait_upd(n);
        check(n >= 3 * TD + 1 && n <= 4 * TD, "R7 restarted window", n, 4 * TD);
        n = 0;
        repeat (60) begin
            @(negedge clk);
            if (gain_upd) n++;
        end
        check(n == 0 && gain_out == 8'h62, "R7 single pulse", n, 0);

        check(exp_q.size() == 0, "R8 all updates seen", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule